// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits in the issue stage of an in-order, two-wide pipeline. Each cycle it receives the two oldest decoded instructions. Slot 0 holds the older one and slot 1 the younger one. Each slot carries a valid flag and a 3-bit instruction class. The block decides whether both instructions leave together, only the older one leaves, or nothing leaves.

The decision depends on which pairs of classes can share the integer register file in one cycle. That file has four read ports and two write ports, split evenly between the integer path and the branch path. Only a few class combinations fit within those ports, so the block uses a fixed pairing table rather than a rule that any two different units may pair.

When only the older instruction issues, the block raises a hold flag. Upstream logic then moves the younger instruction into slot 0 on the next cycle, where it is checked against the next fetched instruction. The decision is registered, so the outputs reflect the slot inputs and the ready input sampled at the previous rising clock edge.

Top module: `dual_issue_pair_check`

## Requirements
- R1: While `rst_n` is low at a rising edge, all three outputs are 0 after that edge.
- R2: `issue0` is 1 exactly one cycle after an edge at which `s0_valid` and `down_ready` were both 1 and reset was inactive.
- R3: `issue1` is never 1 unless `issue0` is 1 in the same cycle, which keeps issue in program order.
- R4: Class codes are 1 integer operate, 2 floating-point operate, 3 load/store, 4 integer branch and 5 floating-point branch. With both slots valid and ready high, the pairs that issue together are {1,2}, {1,3}, {2,3}, {1,4} and {2,5}.
- R5: Pair legality does not depend on slot order. Swapping the two class codes gives the same `issue1` result.
- R6: Any combination not listed in R4 issues only slot 0, including two instructions of the same class (for example two load/stores or two integer operates).
- R7: Code 0 (other) and the undefined codes 6 and 7 never pair, in either slot.
- R8: `hold1` is 1 exactly when `issue0` is 1, slot 1 was valid and `issue1` is 0.
- R9: If slot 0 is invalid or `down_ready` is 0, all outputs are 0 in the next cycle, whatever slot 1 holds.
- R10: If slot 1 is invalid, a ready and valid slot 0 issues alone, and `hold1` stays 0.
- R11: With parameter `DUAL_EN` = 0, `issue1` is never 1 and `hold1` follows R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s0_valid | input | 1 | Older slot holds an instruction |
| s0_class | input | 3 | Class code of the older slot |
| s1_valid | input | 1 | Younger slot holds an instruction |
| s1_class | input | 3 | Class code of the younger slot |
| down_ready | input | 1 | Downstream stage can accept instructions |
| issue0 | output | 1 | Older slot issued |
| issue1 | output | 1 | Younger slot issued along with the older one |
| hold1 | output | 1 | Older slot issued alone; the younger one is kept |

## Verification
The bench builds two copies of the block: one with the default `DUAL_EN` = 1 and one with `DUAL_EN` = 0. Both are driven with the same stimulus. The default copy is swept through all 64 ordered class-code pairs, so the legal pairs, their mirrored orders, the same-class pairs and the undefined codes are all reached. The second copy shows that the single-issue build never pairs. A random phase then varies the valid flags and the ready input to cover the stall cases and the single-valid cases.

// File: rtl/pair_pkg.sv
// Shared definitions for the dual-issue pairing checker.
// Assumes a fixed 3-bit class field on each issue slot.
package pair_pkg;
    localparam int CLS_W   = 3;
    localparam int N_SLOTS = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_OTHER = 3'd0,
        CLS_IOP   = 3'd1,
        CLS_FOP   = 3'd2,
        CLS_MEM   = 3'd3,
        CLS_IBR   = 3'd4,
        CLS_FBR   = 3'd5
    } iclass_e;
endpackage

// File: rtl/pair_class_norm.sv
// Maps a raw class code onto the class enum.
// Assumes any code outside the defined set behaves as "other".
module pair_class_norm
    import pair_pkg::*;
(
    input  logic [CLS_W-1:0] raw_cls,
    output iclass_e          cls
);
    // Fold the undefined codes into CLS_OTHER.
    always_comb begin
        case (raw_cls)
            3'd1:    cls = CLS_IOP;
            3'd2:    cls = CLS_FOP;
            3'd3:    cls = CLS_MEM;
            3'd4:    cls = CLS_IBR;
            3'd5:    cls = CLS_FBR;
            default: cls = CLS_OTHER;
        endcase
    end
endmodule

// File: rtl/pair_legal_table.sv
// Decides whether two normalised classes may issue in the same cycle.
// Assumes the register-file port limits give a symmetric table; each
// class lists the partners it may share a cycle with.
module pair_legal_table
    import pair_pkg::*;
(
    input  iclass_e cls_a,
    input  iclass_e cls_b,
    output logic    legal
);
    localparam int N_CLS = 6;

    logic [N_CLS-1:0] partners;

    // Partner mask of cls_a, indexed by class code.
    always_comb begin
        partners = '0;
        case (cls_a)
            CLS_IOP: begin
                partners[CLS_FOP] = 1'b1;
                partners[CLS_MEM] = 1'b1;
                partners[CLS_IBR] = 1'b1;
            end
            CLS_FOP: begin
                partners[CLS_IOP] = 1'b1;
                partners[CLS_MEM] = 1'b1;
                partners[CLS_FBR] = 1'b1;
            end
            CLS_MEM: begin
                partners[CLS_IOP] = 1'b1;
                partners[CLS_FOP] = 1'b1;
            end
            CLS_IBR: partners[CLS_IOP] = 1'b1;
            CLS_FBR: partners[CLS_FOP] = 1'b1;
            default: partners = '0;
        endcase
    end

    // Look up cls_b in the mask.
    always_comb legal = partners[cls_b];
endmodule

// File: rtl/dual_issue_pair_check.sv
// Dual-issue pairing checker: registers the issue decision for two
// in-order slots. Assumes slot 0 is older, and that upstream shifts
// slot 1 into slot 0 whenever hold1 is high. DUAL_EN = 0 builds a
// single-issue variant.
module dual_issue_pair_check
    import pair_pkg::*;
#(
    parameter bit DUAL_EN = 1'b1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s0_valid,
    input  logic [CLS_W-1:0] s0_class,
    input  logic             s1_valid,
    input  logic [CLS_W-1:0] s1_class,
    input  logic             down_ready,
    output logic             issue0,
    output logic             issue1,
    output logic             hold1
);
    logic [N_SLOTS-1:0][CLS_W-1:0] raw;
    iclass_e                       cls [N_SLOTS];
    logic                          pair_ok;
    logic                          go0, go1, keep1;

    // Collect the raw slot codes for the normaliser loop.
    always_comb begin
        raw[0] = s0_class;
        raw[1] = s1_class;
    end

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_norm
        pair_class_norm u_norm (
            .raw_cls (raw[g]),
            .cls     (cls[g])
        );
    end

    if (DUAL_EN) begin : g_dual
        pair_legal_table u_table (
            .cls_a (cls[0]),
            .cls_b (cls[1]),
            .legal (pair_ok)
        );
    end else begin : g_single
        always_comb pair_ok = 1'b0;
    end

    // Next-cycle decision: the older slot gates the younger one.
    always_comb begin
        go0   = s0_valid && down_ready;
        go1   = go0 && s1_valid && pair_ok;
        keep1 = go0 && s1_valid && !pair_ok;
    end

    // Register the decision with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue0 <= 1'b0;
            issue1 <= 1'b0;
            hold1  <= 1'b0;
        end else begin
            issue0 <= go0;
            issue1 <= go1;
            hold1  <= keep1;
        end
    end
endmodule

// File: rtl/pair_check_sva.sv
// Checker for dual_issue_pair_check, attached by bind below.
// Assumes the one-cycle registered decision described in the brief.
module pair_check_sva
    import pair_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             s0_valid,
    input logic [CLS_W-1:0] s0_class,
    input logic             s1_valid,
    input logic [CLS_W-1:0] s1_class,
    input logic             down_ready,
    input logic             issue0,
    input logic             issue1,
    input logic             hold1
);
    p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue1 |-> issue0);

    p_hold_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold1 |-> (issue0 && !issue1));

    p_issue0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (issue0 == $past(s0_valid && down_ready)));

    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!s0_valid || !down_ready) |-> !(issue0 || issue1 || hold1));

    p_same_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(s0_class == s1_class) |-> !issue1);

    p_undef_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(s0_class == 3'd0 || s0_class > 3'd5 ||
              s1_class == 3'd0 || s1_class > 3'd5) |-> !issue1);

    p_lone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !s1_valid) |-> !(issue1 || hold1));
endmodule

bind dual_issue_pair_check pair_check_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .s0_valid   (s0_valid),
    .s0_class   (s0_class),
    .s1_valid   (s1_valid),
    .s1_class   (s1_class),
    .down_ready (down_ready),
    .issue0     (issue0),
    .issue1     (issue1),
    .hold1      (hold1)
);

// File: tb/test_dual_issue_pair_check.sv
// Bench: a behavioural reference model predicts every output one cycle
// ahead and is compared on each falling edge.
module test_dual_issue_pair_check;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s0_valid = 1'b0, s1_valid = 1'b0, down_ready = 1'b0;
    logic [2:0] s0_class = 3'd0, s1_class = 3'd0;
    logic       issue0, issue1, hold1;
    logic       sg_issue0, sg_issue1, sg_hold1;

    int checks = 0;
    int failures = 0;

    // Inputs applied at the previous falling edge.
    bit p_rst = 1'b0, p_v0 = 1'b0, p_v1 = 1'b0, p_rdy = 1'b0;
    int p_c0 = 0, p_c1 = 0;

    always #10 clk = ~clk;

    dual_issue_pair_check #(.DUAL_EN(1'b1)) i_dual_issue_pair_check (
        .clk(clk), .rst_n(rst_n), .s0_valid(s0_valid), .s0_class(s0_class),
        .s1_valid(s1_valid), .s1_class(s1_class), .down_ready(down_ready),
        .issue0(issue0), .issue1(issue1), .hold1(hold1));

    dual_issue_pair_check #(.DUAL_EN(1'b0)) i_dual_issue_pair_check_single (
        .clk(clk), .rst_n(rst_n), .s0_valid(s0_valid), .s0_class(s0_class),
        .s1_valid(s1_valid), .s1_class(s1_class), .down_ready(down_ready),
        .issue0(sg_issue0), .issue1(sg_issue1), .hold1(sg_hold1));

    // Legal unordered pairs (R4, R5): lower code then higher code.
    function automatic bit ref_pair(int a, int b);
        int lo = (a < b) ? a : b;
        int hi = (a < b) ? b : a;
        return (lo == 1 && hi == 2) || (lo == 1 && hi == 3) ||
               (lo == 2 && hi == 3) || (lo == 1 && hi == 4) ||
               (lo == 2 && hi == 5);
    endfunction

    task automatic check(string req, string what, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b (c0=%0d c1=%0d v0=%0b v1=%0b rdy=%0b)",
                     req, what, act, exp, p_c0, p_c1, p_v0, p_v1, p_rdy);
        end
    endtask

    // Compare against the model, then drive the next inputs.
    task automatic step(bit r, bit v0, int c0, bit v1, int c1, bit rdy);
        bit e0, e1, eh, s1e;
        @(negedge clk);
        e0  = p_rst && p_v0 && p_rdy;
        e1  = e0 && p_v1 && ref_pair(p_c0, p_c1);
        eh  = e0 && p_v1 && !e1;
        s1e = e0 && p_v1;
        if (!p_rst) begin
            check("R1", "issue0", issue0, 1'b0);
            check("R1", "issue1", issue1, 1'b0);
            check("R1", "hold1", hold1, 1'b0);
        end else begin
            check(p_v0 && p_rdy ? "R2" : "R9", "issue0", issue0, e0);
            check(p_v1 ? "R4" : "R10", "issue1", issue1, e1);
            check(p_v1 ? "R8" : "R10", "hold1", hold1, eh);
            check("R11", "single issue1", sg_issue1, 1'b0);
            check("R11", "single hold1", sg_hold1, s1e);
        end
        rst_n = r; s0_valid = v0; s1_valid = v1; down_ready = rdy;
        s0_class = 3'(c0); s1_class = 3'(c1);
        p_rst = r; p_v0 = v0; p_v1 = v1; p_rdy = rdy; p_c0 = c0; p_c1 = c1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        // R1: reset holds all outputs low even with busy inputs.
        step(1'b0, 1'b1, 1, 1'b1, 2, 1'b1);
        step(1'b0, 1'b1, 1, 1'b1, 2, 1'b1);
        // R4 R5 R6 R7: every ordered class pair, both valid, ready high.
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                step(1'b1, 1'b1, a, 1'b1, b, 1'b1);
        // R9: ready low or slot 0 empty blocks a legal pair.
        step(1'b1, 1'b1, 1, 1'b1, 2, 1'b0);
        step(1'b1, 1'b0, 1, 1'b1, 2, 1'b1);
        // R10: lone older slot.
        step(1'b1, 1'b1, 3, 1'b0, 1, 1'b1);
        // R3 R8: mixed random patterns.
        for (int i = 0; i < 600; i++)
            step(1'b1, 1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)),
                 1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)),
                 1'($urandom_range(0, 4) != 0));
        // R1: reset in mid-run.
        step(1'b0, 1'b1, 2, 1'b1, 5, 1'b1);
        step(1'b1, 1'b0, 0, 1'b0, 0, 1'b0);
        step(1'b1, 1'b0, 0, 1'b0, 0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule